// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read and Rewind

This block is a dual-clock first-in first-out buffer. A producer writes on `wclk` and a consumer reads on `rclk`. The read behaviour is fixed at master reset and kept until the next master reset. In standard mode a word reaches `dout` one read-clock edge after a read request. In fall-through mode the oldest word is moved onto `dout` without a request, and a read request consumes it.

The two status outputs keep their pins in both modes, but their meaning depends on the mode. `wr_flag` reports full in standard mode and room-to-write in fall-through mode. `rd_flag` reports empty in standard mode and word-valid in fall-through mode.

There are two resets. Master reset clears the pointers and the output register and samples the mode. Partial reset clears the same state but keeps the mode. A rewind request on the read clock moves the read pointer back to memory slot zero, so that data written since the last reset can be read again. A half-full output shows when the memory holds more than half of its capacity.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low, both pointers and `dout` are cleared to zero. After release the FIFO is empty, `half_full` is 0 and `dout` is 0.
- R2: `mode_ft` is sampled on `wclk` edges while `mrst_n` is low (1 = fall-through, 0 = standard). The mode then holds until the next master reset.
- R3: A low `prst_n` clears both pointers, `dout` and any pending output word, and keeps the current mode.
- R4: In standard mode, a read (`ren` high at a `rclk` edge while not empty) loads the oldest unread word onto `dout` at that edge, in write order.
- R5: In standard mode, `wr_flag` is 1 when the memory is full and `rd_flag` is 1 when it is empty.
- R6: In fall-through mode, the oldest word appears on `dout` with no read request. `rd_flag` is 1 while `dout` holds a valid unread word, and `wr_flag` is 1 while the memory has room. A read request with `rd_flag` high consumes the word, and `dout` holds while no request is made.
- R7: A write while full and a read while empty are ignored, and neither pointer moves.
- R8: `rewind` high at a `rclk` edge sets the read pointer to slot zero and leaves the write pointer unchanged. The words from slot zero onward are then read again, and later writes append after the existing words.
- R9: In the `rclk` cycle after a rewind edge, `rd_flag` reads as empty (standard mode) or not-valid (fall-through mode), whatever the content.
- R10: `half_full` is 1 when the number of words in memory is more than DEPTH/2, and 0 otherwise.
- R11: Full and room-to-write are computed in the `wclk` domain and change on the `wclk` edge of the write that fills the memory. Pointers cross the clock domains as Gray codes through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset, active low, keeps mode |
| mode_ft | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write request |
| din | input | DW | Write data |
| ren | input | 1 | Read request |
| rewind | input | 1 | Rewind read pointer to slot zero |
| dout | output | DW | Read data register |
| wr_flag | output | 1 | Full (standard) or room-to-write (fall-through) |
| rd_flag | output | 1 | Empty (standard) or word-valid (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words in memory |

## Verification
The assertions take three things for granted:
- `mode_ft` is held steady for at least two write-clock edges of every master reset.
- Both resets last several cycles of each clock.
- `rewind` is only raised when no more than DEPTH words have been written since the last reset, so slot zero still holds the oldest word.

The stimulus keeps within these limits. It changes the mode only together with a long reset. It issues rewinds only after a reset followed by a short burst of writes. It drives every input at the falling edge of its own clock, so requests never race the sampling edge. It still raises `wen` while full and `ren` while empty on purpose, to exercise R7.

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_ft,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ren,
  input  logic          rewind,
  output logic [DW-1:0] dout,
  output logic          wr_flag,
  output logic          rd_flag,
  output logic          half_full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic          rst_n;
  logic          ft;
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rq1, rq2;
  logic [AW:0]   rbin, rgray, wq1, wq2;
  logic [AW:0]   wcount;
  logic          full_now, empty_now, do_wr;
  logic          ov, rt_hold, std_rd, ft_fetch, pop;

  assign rst_n = mrst_n & prst_n;

  always_ff @(posedge wclk)
    if (!mrst_n) ft <= mode_ft;

  // write domain
  assign full_now  = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign do_wr     = wen & ~full_now;
  assign wcount    = wbin - g2b(rq2);
  assign half_full = (wcount > HALF);
  assign wr_flag   = ft ? ~full_now : full_now;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin <= '0; wgray <= '0; rq1 <= '0; rq2 <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (do_wr) begin
        wbin  <= wbin + 1'b1;
        wgray <= b2g(wbin + 1'b1);
      end
    end

  always_ff @(posedge wclk)
    if (do_wr) mem[wbin[AW-1:0]] <= din;

  // read domain
  assign empty_now = (rgray == wq2);
  assign std_rd    = ~ft & ren & ~empty_now & ~rt_hold & ~rewind;
  assign ft_fetch  = ft & ~empty_now & ~rewind & (~ov | ren);
  assign pop       = std_rd | ft_fetch;
  assign rd_flag   = ft ? (ov & ~rt_hold) : (empty_now | rt_hold);

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rbin <= '0; rgray <= '0; wq1 <= '0; wq2 <= '0;
      dout <= '0; ov <= 1'b0; rt_hold <= 1'b0;
    end else begin
      wq1     <= wgray;
      wq2     <= wq1;
      rt_hold <= rewind;
      if (rewind) begin
        rbin  <= '0;
        rgray <= '0;
        ov    <= 1'b0;
      end else begin
        if (pop) begin
          rbin  <= rbin + 1'b1;
          rgray <= b2g(rbin + 1'b1);
          dout  <= mem[rbin[AW-1:0]];
        end
        if (ft) ov <= ft_fetch | (ov & ~ren);
      end
    end

  // checks
  assert_mode_hold_R2: assert property (@(posedge wclk) disable iff (!mrst_n)
    $stable(ft));
  assert_no_write_full_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (full_now && wen) |=> (wbin == $past(wbin)));
  assert_no_read_empty_R7: assert property (@(posedge rclk) disable iff (!rst_n)
    (!ft && empty_now && ren && !rewind) |=> (rbin == $past(rbin)));
  assert_rewind_zero_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    rewind |=> (rbin == '0));
  assert_rewind_flag_R9: assert property (@(posedge rclk) disable iff (!rst_n)
    rewind |=> (ft ? !rd_flag : rd_flag));
  assert_ft_hold_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (ft && rd_flag && !ren && !rewind) |=> (rd_flag && $stable(dout)));
  assert_gray_step_R11: assert property (@(posedge wclk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: tb/dual_mode_fifo_tb_top.sv
module dual_mode_fifo_tb_top;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1, mode_ft = 0;
  logic wen = 0, ren = 0, rewind = 0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic wr_flag, rd_flag, half_full;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] expq [0:4095];
  int wr_idx, rd_idx;

  always #10 wclk = ~wclk;
  always #13 rclk = ~rclk;

  dual_mode_fifo #(.DW(DW), .AW(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_ft(mode_ft), .wen(wen), .din(din), .ren(ren), .rewind(rewind),
    .dout(dout), .wr_flag(wr_flag), .rd_flag(rd_flag), .half_full(half_full));

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic mreset(input bit m);
    @(negedge wclk); mrst_n = 0; mode_ft = m;
    repeat (4) @(negedge wclk);
    mrst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk); wen = 1; din = d;
    @(negedge wclk); wen = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic pop_std(output logic [DW-1:0] d);
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0; d = dout;
  endtask

  task automatic take_ft(output logic [DW-1:0] d);
    @(negedge rclk); d = dout; ren = 1;
    @(negedge rclk); ren = 0;
  endtask

  task automatic do_rewind();
    @(negedge rclk); rewind = 1;
    @(negedge rclk); rewind = 0;
  endtask

  task automatic run_random(input bit ftm, input int n);
    wr_idx = 0; rd_idx = 0;
    fork
      begin
        while (wr_idx < n) begin
          @(negedge wclk);
          wen = 0;
          if ($urandom % 2 == 1) begin
            wen = 1;
            din = DW'($urandom);
            if (wr_flag == ftm) begin
              expq[wr_idx] = din;
              wr_idx++;
            end
          end
        end
        @(negedge wclk); wen = 0;
      end
      begin
        bit pend = 0;
        while (rd_idx < n) begin
          @(negedge rclk);
          if (!ftm) begin
            if (pend) begin
              chk("R4 standard data order", dout, expq[rd_idx]);
              rd_idx++;
            end
            pend = (rd_flag == 0) && ($urandom % 3 != 0);
            ren  = pend | (rd_flag && ($urandom % 4 == 0));
          end else begin
            ren = 0;
            if (rd_flag && ($urandom % 3 != 0)) begin
              chk("R6 fall-through data order", dout, expq[rd_idx]);
              rd_idx++;
              ren = 1;
            end
          end
        end
        @(negedge rclk); ren = 0;
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd1234));

    // standard mode reset state
    mreset(0);
    chk("R1 dout after master reset", dout, 0);
    chk("R5 empty after reset", rd_flag, 1);
    chk("R5 not full after reset", wr_flag, 0);
    chk("R10 half_full after reset", half_full, 0);

    // reads while empty are ignored
    @(negedge rclk); ren = 1;
    repeat (4) @(negedge rclk);
    ren = 0;
    push(9'h055);
    settle();
    chk("R5 not empty after write", rd_flag, 0);
    pop_std(d);
    chk("R7 empty read ignored, first word", d, 9'h055);
    settle();
    chk("R5 empty after draining", rd_flag, 1);

    // half full and full boundaries
    mreset(0);
    for (int i = 0; i < DEPTH/2; i++) push(DW'(i + 16));
    chk("R10 half_full at DEPTH/2", half_full, 0);
    push(DW'(DEPTH/2 + 16));
    chk("R10 half_full above DEPTH/2", half_full, 1);
    for (int i = DEPTH/2 + 1; i < DEPTH - 1; i++) push(DW'(i + 16));
    chk("R5 not full one short", wr_flag, 0);
    push(DW'(DEPTH - 1 + 16));
    chk("R11 full on filling wclk edge", wr_flag, 1);
    push(9'h1FF);
    push(9'h1FE);
    settle();
    chk("R5 still full", wr_flag, 1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_std(d);
      chk("R7 write while full ignored, order", d, i + 16);
    end
    settle();
    chk("R7 no extra word after full writes", rd_flag, 1);
    chk("R10 half_full clear when empty", half_full, 0);

    // random traffic, standard mode
    mreset(0);
    run_random(0, 300);

    // rewind in standard mode
    mreset(0);
    for (int i = 0; i < 5; i++) push(DW'(9'h100 + i));
    settle();
    for (int i = 0; i < 3; i++) begin
      pop_std(d);
      chk("R4 read before rewind", d, 9'h100 + i);
    end
    do_rewind();
    chk("R9 empty forced after rewind", rd_flag, 1);
    @(negedge rclk);
    chk("R8 data available after rewind", rd_flag, 0);
    for (int i = 0; i < 5; i++) begin
      pop_std(d);
      chk("R8 reread from slot zero", d, 9'h100 + i);
    end
    push(9'h0AA);
    settle();
    pop_std(d);
    chk("R8 write pointer kept", d, 9'h0AA);

    // fall-through mode
    mreset(1);
    chk("R1 dout after master reset ft", dout, 0);
    chk("R2 R6 not valid after reset", rd_flag, 0);
    chk("R2 R6 ready after reset", wr_flag, 1);
    push(9'h033);
    settle();
    chk("R6 first word falls through", dout, 9'h033);
    chk("R6 output valid", rd_flag, 1);
    repeat (3) @(negedge rclk);
    chk("R6 word held without read", dout, 9'h033);
    take_ft(d);
    settle();
    chk("R6 valid clears after last word", rd_flag, 0);

    // fall-through capacity
    mreset(1);
    push(9'h040);
    settle();
    for (int i = 1; i < DEPTH; i++) push(DW'(9'h040 + i));
    chk("R6 ready with one slot left", wr_flag, 1);
    push(DW'(9'h040 + DEPTH));
    chk("R6 ready drops when memory full", wr_flag, 0);
    push(9'h1FF);
    settle();
    for (int i = 0; i <= DEPTH; i++) begin
      if (i > 0) repeat (3) @(negedge rclk);
      take_ft(d);
      chk("R7 ft order, full write ignored", d, 9'h040 + i);
    end
    settle();
    chk("R7 ft no extra word", rd_flag, 0);

    // random traffic, fall-through mode
    mreset(1);
    run_random(1, 300);

    // rewind in fall-through mode
    mreset(1);
    for (int i = 0; i < 4; i++) push(DW'(9'h0C0 + i));
    settle();
    take_ft(d);
    repeat (3) @(negedge rclk);
    take_ft(d);
    settle();
    chk("R6 third word on output", dout, 9'h0C2);
    do_rewind();
    chk("R9 output-ready drops after rewind", rd_flag, 0);
    settle();
    chk("R8 ft rewinds to slot zero", dout, 9'h0C0);
    chk("R8 ft valid after rewind", rd_flag, 1);

    // partial reset keeps mode
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge wclk);
    prst_n = 1;
    settle();
    chk("R3 dout cleared", dout, 0);
    chk("R3 no valid word", rd_flag, 0);
    chk("R3 mode kept, ready polarity", wr_flag, 1);
    push(9'h07E);
    settle();
    chk("R3 fall-through still active", dout, 9'h07E);
    chk("R3 valid flag", rd_flag, 1);

    // back to standard
    mreset(0);
    chk("R2 standard after new master reset", wr_flag, 0);
    chk("R2 empty polarity", rd_flag, 1);
    push(9'h011);
    settle();
    chk("R2 no fall-through in standard", dout, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule